// File: doc/BRIEF.md
# Trap Entry and Return Controller

This block sits beside the control sequencer of a 64-bit multi-cycle core and handles precise trap entry and trap return. When the core raises one or more trap causes, the block saves the address of the faulting instruction, records a syndrome code, and supplies the handler address for the next fetch. The saved address is the current PC minus 4, because the core has already advanced the PC past the faulting instruction. The handler address is the vector base plus the cause number times 64 bytes. A return command sends the PC back to the saved link address.

Four system registers are reachable through a read and write port. The core uses this port for its move-to-system-register and move-from-system-register instructions. The registers are never ALU operands. A floating-point overflow also sets a sticky flag in a status register, and only a software write clears that flag.

The controller is a three-state machine:
- `ST_IDLE` waits. On a request (transition *take*) it goes to `ST_ENTER`. On a return strobe with no request (transition *ret*) it goes to `ST_RETURN`.
- `ST_ENTER` presents the handler address for one cycle, then goes back to `ST_IDLE` (transition *enter_done*).
- `ST_RETURN` presents the link address for one cycle, then goes back to `ST_IDLE` (transition *return_done*).

Top module: `trap_ctrl`

## Requirements
- R1: After reset all four system registers read zero and `new_pc_valid` is low.
- R2: On trap entry the link register (index 0) is loaded with `cur_pc` minus 4.
- R3: On entry the syndrome register (index 1) is loaded with a code for the winning cause, zero-extended. The codes are: cause 0 (undefined instruction) 0x04, cause 1 (arithmetic overflow) 0x11, cause 2 (floating-point overflow) 0x2C, cause 3 (service call) 0x15.
- R4: The cycle after a request, `new_pc_valid` is high and `new_pc` equals the vector base (index 2) plus the cause number times 64.
- R5: When several causes are requested in the same cycle, the lowest-numbered one wins and exactly one entry is taken.
- R6: Cause 1 is also raised when `alu_chk` and `alu_v` are both high. `alu_v` alone has no effect.
- R7: A cause-2 entry sets bit 2 of the status register (index 3). The bit stays set until software writes that register.
- R8: A return strobe while idle makes `new_pc_valid` high the next cycle with `new_pc` equal to the link register.
- R9: `new_pc_valid` is high for exactly one cycle per entry or return. Requests and return strobes that arrive during that cycle are ignored.
- R10: Indices 0 to 3 select link, syndrome, vector base and status. Other indices read zero and writes to them are ignored. A vector base write is used by a trap raised in the following cycle.
- R11: A trap takes precedence over a return strobe in the same cycle. The entry updates of link and syndrome take precedence over a software write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| exc_req | input | 4 | One request bit per cause number |
| alu_chk | input | 1 | Instruction traps on signed overflow |
| alu_v | input | 1 | ALU overflow condition code |
| cur_pc | input | 64 | Already-incremented PC |
| eret | input | 1 | Trap-return strobe |
| sr_wen | input | 1 | System register write enable |
| sr_idx | input | 3 | System register index |
| sr_wdata | input | 64 | System register write data |
| sr_rdata | output | 64 | System register read data (combinational) |
| new_pc | output | 64 | Redirect target |
| new_pc_valid | output | 1 | Redirect strobe |

## Verification
A wrong priority or a stale cause register shows at the ports one cycle after the request. It appears as a handler address that is off by a multiple of 64, and as a syndrome that does not match the lowest set request bit. A bad link register is only exposed on the return one cycle after the return strobe, so every entry in the sweep is followed by a round trip back to PC minus 4. A lost or cleared sticky flag stays hidden until the status register is read, so the bench reads it after every entry.

// File: rtl/trap_pkg.sv
package trap_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ENTER,
        ST_RETURN
    } trap_state_e;

    localparam logic [2:0] SR_LINK  = 3'd0;
    localparam logic [2:0] SR_SYND  = 3'd1;
    localparam logic [2:0] SR_VBASE = 3'd2;
    localparam logic [2:0] SR_FSTAT = 3'd3;

    localparam int FSTAT_OVF_BIT = 2;

    function automatic logic [5:0] synd_code(input int unsigned cause);
        logic [5:0] code;
        case (cause)
            0:       code = 6'h04;
            1:       code = 6'h11;
            2:       code = 6'h2C;
            3:       code = 6'h15;
            default: code = 6'(cause);
        endcase
        return code;
    endfunction

endpackage

// File: rtl/trap_prio.sv
module trap_prio #(
    parameter int NCAUSE = 4,
    localparam int CW = (NCAUSE > 1) ? $clog2(NCAUSE) : 1
) (
    input  logic [NCAUSE-1:0] req,
    output logic              any,
    output logic [CW-1:0]     cause
);

    logic [NCAUSE-1:0] grant;
    logic [NCAUSE-1:0] lower_busy;

    assign lower_busy[0] = 1'b0;
    assign grant[0]      = req[0];

    generate
        for (genvar i = 1; i < NCAUSE; i++) begin : g_chain
            assign lower_busy[i] = lower_busy[i-1] | req[i-1];
            assign grant[i]      = req[i] & ~lower_busy[i];
        end
    endgenerate

    always_comb begin
        cause = '0;
        for (int i = 0; i < NCAUSE; i++) begin
            if (grant[i]) cause = cause | CW'(i);
        end
    end

    assign any = |req;

endmodule

// File: rtl/trap_sysregs.sv
module trap_sysregs
    import trap_pkg::*;
#(
    parameter int XLEN       = 64,
    parameter int NCAUSE     = 4,
    parameter int INSN_BYTES = 4,
    parameter int FP_CAUSE   = 2,
    localparam int CW = (NCAUSE > 1) ? $clog2(NCAUSE) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            take,
    input  logic [CW-1:0]   take_cause,
    input  logic [XLEN-1:0] take_pc,
    input  logic            wen,
    input  logic [2:0]      idx,
    input  logic [XLEN-1:0] wdata,
    output logic [XLEN-1:0] rdata,
    output logic [XLEN-1:0] link_q,
    output logic [XLEN-1:0] synd_q,
    output logic [XLEN-1:0] vbase_q,
    output logic [XLEN-1:0] fstat_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            link_q  <= '0;
            synd_q  <= '0;
            vbase_q <= '0;
            fstat_q <= '0;
        end else begin
            if (wen) begin
                case (idx)
                    SR_LINK:  link_q  <= wdata;
                    SR_SYND:  synd_q  <= wdata;
                    SR_VBASE: vbase_q <= wdata;
                    SR_FSTAT: fstat_q <= wdata;
                    default:  ;
                endcase
            end
            if (take) begin
                link_q <= take_pc - XLEN'(INSN_BYTES);
                synd_q <= XLEN'(synd_code(int'(take_cause)));
                if (int'(take_cause) == FP_CAUSE) begin
                    fstat_q[FSTAT_OVF_BIT] <= 1'b1;
                end
            end
        end
    end

    always_comb begin
        case (idx)
            SR_LINK:  rdata = link_q;
            SR_SYND:  rdata = synd_q;
            SR_VBASE: rdata = vbase_q;
            SR_FSTAT: rdata = fstat_q;
            default:  rdata = '0;
        endcase
    end

endmodule

// File: rtl/trap_fsm.sv
module trap_fsm
    import trap_pkg::*;
#(
    parameter int XLEN      = 64,
    parameter int NCAUSE    = 4,
    parameter int VEC_SHIFT = 6,
    localparam int CW = (NCAUSE > 1) ? $clog2(NCAUSE) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            any_req,
    input  logic [CW-1:0]   cause,
    input  logic            eret,
    input  logic [XLEN-1:0] vbase,
    input  logic [XLEN-1:0] link,
    output logic            take,
    output trap_state_e     state,
    output logic [XLEN-1:0] new_pc,
    output logic            new_pc_valid
);

    trap_state_e state_d;
    logic [CW-1:0] cause_q;

    always_comb begin
        state_d = state;
        take    = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (any_req) begin
                    take    = 1'b1;
                    state_d = ST_ENTER;
                end else if (eret) begin
                    state_d = ST_RETURN;
                end
            end
            ST_ENTER:  state_d = ST_IDLE;
            ST_RETURN: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            cause_q <= '0;
        end else begin
            state <= state_d;
            if (take) cause_q <= cause;
        end
    end

    always_comb begin
        new_pc_valid = 1'b0;
        new_pc       = '0;
        unique case (state)
            ST_IDLE: ;
            ST_ENTER: begin
                new_pc_valid = 1'b1;
                new_pc       = vbase + (XLEN'(cause_q) << VEC_SHIFT);
            end
            ST_RETURN: begin
                new_pc_valid = 1'b1;
                new_pc       = link;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/trap_ctrl.sv
module trap_ctrl
    import trap_pkg::*;
#(
    parameter int XLEN        = 64,
    parameter int NCAUSE      = 4,
    parameter int VEC_SHIFT   = 6,
    parameter int INSN_BYTES  = 4,
    parameter int ARITH_CAUSE = 1,
    parameter int FP_CAUSE    = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NCAUSE-1:0] exc_req,
    input  logic              alu_chk,
    input  logic              alu_v,
    input  logic [XLEN-1:0]   cur_pc,
    input  logic              eret,
    input  logic              sr_wen,
    input  logic [2:0]        sr_idx,
    input  logic [XLEN-1:0]   sr_wdata,
    output logic [XLEN-1:0]   sr_rdata,
    output logic [XLEN-1:0]   new_pc,
    output logic              new_pc_valid
);

    localparam int CW = (NCAUSE > 1) ? $clog2(NCAUSE) : 1;

    logic [NCAUSE-1:0] req_all;
    logic              any_req;
    logic [CW-1:0]     win_cause;
    logic              take;
    trap_state_e       state;
    logic [XLEN-1:0]   link_q, synd_q, vbase_q, fstat_q;

    always_comb begin
        req_all = exc_req;
        req_all[ARITH_CAUSE] = exc_req[ARITH_CAUSE] | (alu_chk & alu_v);
    end

    trap_prio #(.NCAUSE(NCAUSE)) u_prio (
        .req   (req_all),
        .any   (any_req),
        .cause (win_cause)
    );

    trap_fsm #(.XLEN(XLEN), .NCAUSE(NCAUSE), .VEC_SHIFT(VEC_SHIFT)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .any_req      (any_req),
        .cause        (win_cause),
        .eret         (eret),
        .vbase        (vbase_q),
        .link         (link_q),
        .take         (take),
        .state        (state),
        .new_pc       (new_pc),
        .new_pc_valid (new_pc_valid)
    );

    trap_sysregs #(
        .XLEN(XLEN), .NCAUSE(NCAUSE), .INSN_BYTES(INSN_BYTES), .FP_CAUSE(FP_CAUSE)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .take       (take),
        .take_cause (win_cause),
        .take_pc    (cur_pc),
        .wen        (sr_wen),
        .idx        (sr_idx),
        .wdata      (sr_wdata),
        .rdata      (sr_rdata),
        .link_q     (link_q),
        .synd_q     (synd_q),
        .vbase_q    (vbase_q),
        .fstat_q    (fstat_q)
    );

endmodule

// File: rtl/trap_ctrl_chk.sv
module trap_ctrl_chk
    import trap_pkg::*;
#(
    parameter int XLEN       = 64,
    parameter int NCAUSE     = 4,
    parameter int VEC_SHIFT  = 6,
    parameter int INSN_BYTES = 4,
    localparam int CW = (NCAUSE > 1) ? $clog2(NCAUSE) : 1
) (
    input logic              clk,
    input logic              rst_n,
    input trap_state_e       state,
    input logic [NCAUSE-1:0] req_all,
    input logic              any_req,
    input logic [CW-1:0]     win_cause,
    input logic [XLEN-1:0]   cur_pc,
    input logic              eret,
    input logic              sr_wen,
    input logic [2:0]        sr_idx,
    input logic [XLEN-1:0]   link_q,
    input logic [XLEN-1:0]   synd_q,
    input logic [XLEN-1:0]   vbase_q,
    input logic [XLEN-1:0]   fstat_q,
    input logic [XLEN-1:0]   new_pc,
    input logic              new_pc_valid
);

    assert_single_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        new_pc_valid |=> !new_pc_valid);

    assert_link_saved_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && any_req) |=> (link_q == $past(cur_pc) - XLEN'(INSN_BYTES)));

    assert_undef_code_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && req_all[0]) |=> (synd_q == XLEN'(6'h04)));

    assert_vector_addr_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && any_req && !(sr_wen && sr_idx == SR_VBASE)) |=>
        (new_pc_valid && new_pc == $past(vbase_q) + (XLEN'($past(win_cause)) << VEC_SHIFT)));

    assert_sticky_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (fstat_q[FSTAT_OVF_BIT] && !(sr_wen && sr_idx == SR_FSTAT)) |=> fstat_q[FSTAT_OVF_BIT]);

    assert_return_target_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !any_req && eret && !sr_wen) |=>
        (new_pc_valid && new_pc == $past(link_q)));

endmodule

bind trap_ctrl trap_ctrl_chk #(
    .XLEN(XLEN), .NCAUSE(NCAUSE), .VEC_SHIFT(VEC_SHIFT), .INSN_BYTES(INSN_BYTES)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .state        (state),
    .req_all      (req_all),
    .any_req      (any_req),
    .win_cause    (win_cause),
    .cur_pc       (cur_pc),
    .eret         (eret),
    .sr_wen       (sr_wen),
    .sr_idx       (sr_idx),
    .link_q       (link_q),
    .synd_q       (synd_q),
    .vbase_q      (vbase_q),
    .fstat_q      (fstat_q),
    .new_pc       (new_pc),
    .new_pc_valid (new_pc_valid)
);

// File: tb/trap_ctrl_bench.sv
module trap_ctrl_bench;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  exc_req = '0;
    logic        alu_chk = 1'b0;
    logic        alu_v = 1'b0;
    logic [63:0] cur_pc = '0;
    logic        eret = 1'b0;
    logic        sr_wen = 1'b0;
    logic [2:0]  sr_idx = '0;
    logic [63:0] sr_wdata = '0;
    logic [63:0] sr_rdata;
    logic [63:0] new_pc;
    logic        new_pc_valid;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    trap_ctrl u_trap_ctrl (
        .clk(clk), .rst_n(rst_n), .exc_req(exc_req), .alu_chk(alu_chk), .alu_v(alu_v),
        .cur_pc(cur_pc), .eret(eret), .sr_wen(sr_wen), .sr_idx(sr_idx),
        .sr_wdata(sr_wdata), .sr_rdata(sr_rdata), .new_pc(new_pc),
        .new_pc_valid(new_pc_valid)
    );

    function automatic logic [63:0] exp_code(input int c);
        case (c)
            0: return 64'h04;
            1: return 64'h11;
            2: return 64'h2C;
            default: return 64'h15;
        endcase
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic rd(input logic [2:0] idx, output logic [63:0] v);
        sr_idx = idx;
        #1;
        v = sr_rdata;
    endtask

    task automatic wr(input logic [2:0] idx, input logic [63:0] d);
        sr_wen = 1'b1; sr_idx = idx; sr_wdata = d;
        @(negedge clk);
        sr_wen = 1'b0;
    endtask

    task automatic raise(input logic [3:0] m, input logic [63:0] pc);
        exc_req = m; cur_pc = pc;
        @(negedge clk);
        exc_req = '0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [63:0] v;
        logic [63:0] vb;
        bit flag;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        chk("R1 valid after reset", 64'(new_pc_valid), 64'd0);
        for (int i = 0; i < 4; i++) begin
            rd(3'(i), v);
            chk("R1 sysreg after reset", v, 64'd0);
        end

        vb = 64'h8000;
        wr(3'd2, vb);
        rd(3'd2, v);
        chk("R10 vbase readback", v, vb);

        flag = 1'b0;
        for (int m = 1; m < 16; m++) begin
            int win;
            logic [63:0] pc;
            win = 0;
            for (int b = 3; b >= 0; b--) if (m[b]) win = b;
            pc = 64'h1000 + 64'(m) * 64'h40 + 64'h4;
            raise(4'(m), pc);
            chk("R4 valid on entry", 64'(new_pc_valid), 64'd1);
            chk("R4 R5 handler address", new_pc, vb + 64'(win) * 64);
            rd(3'd0, v); chk("R2 link", v, pc - 4);
            rd(3'd1, v); chk("R3 R5 syndrome", v, exp_code(win));
            if (win == 2) flag = 1'b1;
            rd(3'd3, v); chk("R7 sticky flag", v, {61'd0, flag, 2'd0});
            @(negedge clk);
            chk("R9 single cycle entry", 64'(new_pc_valid), 64'd0);
            eret = 1'b1;
            @(negedge clk);
            eret = 1'b0;
            chk("R8 return valid", 64'(new_pc_valid), 64'd1);
            chk("R8 return target", new_pc, pc - 4);
            @(negedge clk);
            chk("R9 single cycle return", 64'(new_pc_valid), 64'd0);
        end

        wr(3'd3, 64'd0);
        rd(3'd3, v); chk("R7 flag cleared by write", v, 64'd0);

        alu_v = 1'b1;
        @(negedge clk);
        alu_v = 1'b0;
        chk("R6 alu_v alone ignored", 64'(new_pc_valid), 64'd0);
        alu_v = 1'b1; alu_chk = 1'b1; cur_pc = 64'h2224;
        @(negedge clk);
        alu_v = 1'b0; alu_chk = 1'b0;
        chk("R6 arith overflow handler", new_pc, vb + 64);
        rd(3'd1, v); chk("R6 arith overflow syndrome", v, 64'h11);
        rd(3'd0, v); chk("R6 arith overflow link", v, 64'h2220);
        @(negedge clk);

        vb = 64'h20000;
        wr(3'd2, vb);
        raise(4'b1000, 64'h3004);
        chk("R10 new base used", new_pc, vb + 192);
        @(negedge clk);

        wr(3'd5, 64'hDEAD);
        rd(3'd5, v); chk("R10 unused index reads zero", v, 64'd0);
        rd(3'd2, v); chk("R10 unused write ignored", v, vb);

        eret = 1'b1;
        raise(4'b0001, 64'h4008);
        eret = 1'b0;
        chk("R11 trap beats return", new_pc, vb);
        @(negedge clk);
        chk("R11 single redirect", 64'(new_pc_valid), 64'd0);

        sr_wen = 1'b1; sr_idx = 3'd0; sr_wdata = 64'h5555;
        raise(4'b0100, 64'h5010);
        sr_wen = 1'b0;
        rd(3'd0, v); chk("R11 entry beats link write", v, 64'h500C);

        exc_req = 4'b0010; cur_pc = 64'h6004; eret = 1'b1;
        @(negedge clk);
        exc_req = '0; eret = 1'b0;
        chk("R9 ignored while busy", 64'(new_pc_valid), 64'd0);
        rd(3'd0, v); chk("R9 link untouched while busy", v, 64'h500C);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule